// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block turns 32 external interrupt pins into interrupt requests for a processor. Every pin is brought into the clock domain by a two-stage synchroniser. It is then tested against its own trigger condition: a low level, a high level, a falling edge, a rising edge or either edge. A matching condition sets a pending flag for that pin. Software clears the flag by writing a one to it. A per-pin mask bit decides whether the pending flag reaches an interrupt output.

Pins 0 to 15 each have a dedicated request output. Pins 16 to 31 share a single request output, so a handler reached through it reads the pending and mask registers to find the source. A plain register bus reaches four banks of four 32-bit registers. The bus has an address, a write strobe, write data and combinational read data. The filter-configuration bank is storage only; no logic uses its contents.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The 3-bit trigger code selects the condition. Code 0 is low level, 1 is high level, 2 is falling edge, 3 is rising edge and 4 is either edge. Codes 5, 6 and 7 never set a pending flag.
- R2: Trigger register k (address 0xE00 + 4k) holds pins 8k to 8k+7. Pin 8k+b uses bits [4b+2:4b]. The fourth bit of each nibble reads back 0.
- R3: Filter register k sits at 0xE80 + 4k. It stores and returns all 32 written bits and affects nothing else.
- R4: Mask register k (0xF00 + 4k) holds pin 8k+b in bit b, and bits [31:8] read 0. A mask bit of 1 blocks the pin's request, and 0 lets it through.
- R5: Pending register k (0xF40 + 4k) holds pin 8k+b in bit b. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: A pin change that meets an edge trigger shows in the pending flag after the third rising clock edge that follows the change. An edge flag stays set until it is cleared.
- R7: When an edge is detected in the same cycle as a clear of that flag, the flag stays set.
- R8: In level modes the flag is set again every cycle while the level is active, so a clear only takes effect once the pin is inactive.
- R9: irq_direct_o[n] equals pending AND NOT mask for pin n, for n from 0 to 15.
- R10: irq_shared_o is the OR of pending AND NOT mask over pins 16 to 31.
- R11: While reset is asserted, every mask bit is 1 and every pending bit is 0. All trigger and filter fields read 0, and no request output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | External interrupt pins, asynchronous |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, applied at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_direct_o | output | 16 | Dedicated requests for pins 0 to 15 |
| irq_shared_o | output | 1 | Combined request for pins 16 to 31 |

## Verification
The bench runs each of the 32 pins through all five trigger codes. Each run uses the same sequence: hold the pin high, drop it, raise it again, and clear the flag after each step. Reading the flag before and after each clear separates the level codes from the edge codes and the falling edge from the rising edge. It also shows that the flag is sticky after a level ends. In every step the pin's request output is compared with its pending bit, which separates the dedicated path from the shared one. Separate patterns cover the unused codes, a clear that lands in the same cycle as an edge or one cycle after it, two shared pins cleared one at a time, masking, and register readback.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int TRIG_W = 3;
  localparam int NIB_W  = 4;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  localparam logic [11:0] BASE_TRIG = 12'hE00;
  localparam logic [11:0] BASE_FILT = 12'hE80;
  localparam logic [11:0] BASE_MASK = 12'hF00;
  localparam logic [11:0] BASE_PEND = 12'hF40;
endpackage

// File: rtl/eint_rst_sync.sv
module eint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int          WIDTH   = 32,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {WIDTH{RST_VAL}};
      sync_o <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/eint_line.sv
module eint_line
  import eint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_i,
  input  logic [TRIG_W-1:0] mode_i,
  input  logic              clr_i,
  output logic              pend_o
);
  logic prev_q;
  logic pend_q;
  logic hit;
  logic pend_d;

  always_comb begin
    case (trig_e'(mode_i))
      TRIG_LOW:  hit = ~smp_i;
      TRIG_HIGH: hit = smp_i;
      TRIG_FALL: hit = prev_q & ~smp_i;
      TRIG_RISE: hit = ~prev_q & smp_i;
      TRIG_BOTH: hit = prev_q ^ smp_i;
      default:   hit = 1'b0;
    endcase
    pend_d = hit | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R5
  pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(clr_i));

  // R7
  edge_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TRIG_BOTH && smp_i != prev_q && clr_i) |=> pend_q);

  // R8
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == TRIG_LOW && !smp_i) || (mode_i == TRIG_HIGH && smp_i)) |=> pend_q);

  // R1
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i > TRIG_BOTH && !pend_q) |=> !pend_q);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eint_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int LPR       = 8,
  parameter int DIRECT    = 16,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DIRECT-1:0] irq_direct_o,
  output logic              irq_shared_o
);
  localparam int NREG  = NUM_LINES / LPR;
  localparam int IDX_W = $clog2(NREG);
  localparam int LB_W  = $clog2(LPR);
  localparam int SPAN  = NREG * 4;

  logic rst_q_n;
  logic [NUM_LINES-1:0] smp;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] clr;
  logic [NUM_LINES-1:0] irq_line;

  logic [NUM_LINES-1:0][TRIG_W-1:0] mode_q, mode_d;
  logic [NUM_LINES-1:0]             mask_q, mask_d;
  logic [NREG-1:0][DATA_W-1:0]      filt_q, filt_d;

  logic [ADDR_W-1:0] off_trig, off_filt, off_mask, off_pend;
  logic sel_trig, sel_filt, sel_mask, sel_pend;
  logic [IDX_W-1:0] idx_trig, idx_filt, idx_mask, idx_pend;
  logic wr_trig, wr_filt, wr_mask, wr_pend;

  eint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  eint_sync #(.WIDTH(NUM_LINES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .async_i (pin_i),
    .sync_o  (smp)
  );

  // address decode: offset from each bank base, word aligned, inside span
  always_comb begin
    off_trig = bus_addr - ADDR_W'(BASE_TRIG);
    off_filt = bus_addr - ADDR_W'(BASE_FILT);
    off_mask = bus_addr - ADDR_W'(BASE_MASK);
    off_pend = bus_addr - ADDR_W'(BASE_PEND);
    sel_trig = (off_trig < ADDR_W'(SPAN)) && (off_trig[1:0] == 2'b00);
    sel_filt = (off_filt < ADDR_W'(SPAN)) && (off_filt[1:0] == 2'b00);
    sel_mask = (off_mask < ADDR_W'(SPAN)) && (off_mask[1:0] == 2'b00);
    sel_pend = (off_pend < ADDR_W'(SPAN)) && (off_pend[1:0] == 2'b00);
    idx_trig = off_trig[IDX_W+1:2];
    idx_filt = off_filt[IDX_W+1:2];
    idx_mask = off_mask[IDX_W+1:2];
    idx_pend = off_pend[IDX_W+1:2];
    wr_trig  = bus_we & sel_trig;
    wr_filt  = bus_we & sel_filt;
    wr_mask  = bus_we & sel_mask;
    wr_pend  = bus_we & sel_pend;
  end

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    localparam int REG = gi / LPR;
    localparam int BIT = gi % LPR;
    localparam logic [IDX_W-1:0] RIDX = IDX_W'(REG);

    assign mode_d[gi] = (wr_trig && idx_trig == RIDX) ?
                        bus_wdata[NIB_W*BIT +: TRIG_W] : mode_q[gi];
    assign mask_d[gi] = (wr_mask && idx_mask == RIDX) ? bus_wdata[BIT] : mask_q[gi];
    assign clr[gi]    = wr_pend && (idx_pend == RIDX) && bus_wdata[BIT];

    eint_line u_line (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .smp_i  (smp[gi]),
      .mode_i (mode_q[gi]),
      .clr_i  (clr[gi]),
      .pend_o (pend[gi])
    );

    assign irq_line[gi] = pend[gi] & ~mask_q[gi];
  end

  for (genvar ri = 0; ri < NREG; ri++) begin : g_filt
    assign filt_d[ri] = (wr_filt && idx_filt == IDX_W'(ri)) ? bus_wdata : filt_q[ri];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= '0;
      mask_q <= '1;
      filt_q <= '0;
    end else if (bus_we) begin
      mode_q <= mode_d;
      mask_q <= mask_d;
      filt_q <= filt_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_trig) begin
      for (int b = 0; b < LPR; b++)
        bus_rdata[NIB_W*b +: TRIG_W] = mode_q[{idx_trig, LB_W'(b)}];
    end else if (sel_filt) begin
      bus_rdata = filt_q[idx_filt];
    end else if (sel_mask) begin
      for (int b = 0; b < LPR; b++)
        bus_rdata[b] = mask_q[{idx_mask, LB_W'(b)}];
    end else if (sel_pend) begin
      for (int b = 0; b < LPR; b++)
        bus_rdata[b] = pend[{idx_pend, LB_W'(b)}];
    end
  end

  assign irq_direct_o = irq_line[DIRECT-1:0];
  assign irq_shared_o = |irq_line[NUM_LINES-1:DIRECT];

  for (genvar ci = 0; ci < DIRECT; ci++) begin : g_dchk
    // R9
    direct_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      irq_direct_o[ci] |-> (pend[ci] && !mask_q[ci]));
  end

  // R10
  shared_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_shared_o |-> (|pend[NUM_LINES-1:DIRECT]));

  // R11
  reset_out_chk: assert property (@(posedge clk)
    !rst_q_n |-> (irq_direct_o == '0 && !irq_shared_o));
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_i;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] irq_direct_o;
  logic        irq_shared_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_i        (pin_i),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq_direct_o (irq_direct_o),
    .irq_shared_o (irq_shared_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    pin_i[n] = v;
  endtask

  // reads the pin's pending register and the request outputs at one instant
  task automatic chk_line(input string tag, input int n, input logic e);
    logic [31:0] d;
    rd(12'hF40 + 12'(4*(n/8)), d);
    chk({tag, " pending"}, d, 32'(e) << (n%8));
    if (n < 16) begin
      chk({tag, " R9 direct"}, {16'h0, irq_direct_o}, 32'(e) << n);
      chk({tag, " R10 shared idle"}, {31'h0, irq_shared_o}, 32'h0);
    end else begin
      chk({tag, " R9 direct idle"}, {16'h0, irq_direct_o}, 32'h0);
      chk({tag, " R10 shared"}, {31'h0, irq_shared_o}, 32'(e));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; pin_i = '1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);

    // R11 reset state read while reset is held
    for (int k = 0; k < 4; k++) begin
      rd(12'hE00 + 12'(4*k), d); chk("R11 trig reset", d, 32'h0);
      rd(12'hE80 + 12'(4*k), d); chk("R11 filt reset", d, 32'h0);
      rd(12'hF00 + 12'(4*k), d); chk("R11 mask reset", d, 32'hFF);
      rd(12'hF40 + 12'(4*k), d); chk("R11 pend reset", d, 32'h0);
    end
    chk("R11 outputs in reset", {15'h0, irq_shared_o, irq_direct_o}, 32'h0);

    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R2 field layout and unused nibble bit
    wr(12'hE04, 32'hFFFF_FFFF);
    rd(12'hE04, d); chk("R2 trig readback", d, 32'h7777_7777);
    wr(12'hE04, 32'h0);
    rd(12'hE04, d); chk("R2 trig cleared", d, 32'h0);
    // R3 filter storage
    wr(12'hE88, 32'hDEAD_BEEF);
    rd(12'hE88, d); chk("R3 filt readback", d, 32'hDEAD_BEEF);
    rd(12'hE8C, d); chk("R3 filt neighbour", d, 32'h0);
    // R4 mask width
    wr(12'hF0C, 32'hFFFF_FF00);
    rd(12'hF0C, d); chk("R4 mask upper ignored", d, 32'h0);
    wr(12'hF0C, 32'h0000_00A5);
    rd(12'hF0C, d); chk("R4 mask readback", d, 32'hA5);
    wr(12'hF0C, 32'hFF);

    // R1 R6 R8 sweep of all pins and all valid codes
    for (int n = 0; n < 32; n++) begin
      for (int m = 0; m < 5; m++) begin
        logic [11:0] ta, ma, pa;
        int b;
        b  = n % 8;
        ta = 12'hE00 + 12'(4*(n/8));
        ma = 12'hF00 + 12'(4*(n/8));
        pa = 12'hF40 + 12'(4*(n/8));
        wr(ta, 32'(m) << (4*b));
        wr(ma, ~(32'h1 << b) & 32'hFF);
        repeat (4) @(posedge clk);
        wr(pa, 32'hFF);
        chk_line($sformatf("R8 pin%0d code%0d idle-high after clear", n, m), n, m == 1);
        set_pin(n, 1'b0);
        repeat (3) @(posedge clk);
        chk_line($sformatf("R6 pin%0d code%0d after fall", n, m), n, m != 3);
        wr(pa, 32'hFF);
        chk_line($sformatf("R8 pin%0d code%0d low after clear", n, m), n, m == 0);
        set_pin(n, 1'b1);
        repeat (3) @(posedge clk);
        chk_line($sformatf("R1 pin%0d code%0d after rise", n, m), n, m != 2);
        wr(pa, 32'hFF);
        chk_line($sformatf("R5 pin%0d code%0d final clear", n, m), n, m == 1);
        wr(ma, 32'hFF);
        wr(ta, 32'h0);
        wr(pa, 32'hFF);
      end
    end

    // R1 unused codes never set pending (pin 9)
    for (int c = 5; c < 8; c++) begin
      wr(12'hE04, 32'(c) << 4);
      wr(12'hF04, 32'hFD);
      wr(12'hF44, 32'hFF);
      set_pin(9, 1'b0); repeat (4) @(posedge clk);
      set_pin(9, 1'b1); repeat (4) @(posedge clk);
      chk_line($sformatf("R1 unused code %0d", c), 9, 1'b0);
    end
    wr(12'hE04, 32'h0); wr(12'hF04, 32'hFF);

    // R7 clear in the same cycle as a rising edge on pin 3
    wr(12'hE00, 32'h3 << 12);
    wr(12'hF00, 32'hF7);
    set_pin(3, 1'b0); repeat (4) @(posedge clk);
    wr(12'hF40, 32'hFF);
    set_pin(3, 1'b1);
    @(posedge clk); @(posedge clk);
    wr(12'hF40, 32'h08);
    chk_line("R7 set wins over same-cycle clear", 3, 1'b1);
    // control: clear one cycle after detection removes it
    set_pin(3, 1'b0); repeat (4) @(posedge clk);
    wr(12'hF40, 32'hFF);
    set_pin(3, 1'b1);
    @(posedge clk); @(posedge clk); @(posedge clk);
    wr(12'hF40, 32'h08);
    chk_line("R7 later clear takes effect", 3, 1'b0);
    // R5 writing zero leaves the flag alone
    set_pin(3, 1'b0); repeat (4) @(posedge clk);
    set_pin(3, 1'b1); repeat (4) @(posedge clk);
    wr(12'hF40, 32'hF7);
    chk_line("R5 write zero keeps flag", 3, 1'b1);
    wr(12'hF40, 32'hFF);
    wr(12'hE00, 32'h0); wr(12'hF00, 32'hFF);

    // R4 R10 masking of a shared pin (pin 20)
    wr(12'hE08, 32'h3 << 16);
    set_pin(20, 1'b0); repeat (4) @(posedge clk);
    wr(12'hF48, 32'hFF);
    set_pin(20, 1'b1); repeat (4) @(posedge clk);
    rd(12'hF48, d); chk("R4 masked pin still pending", d, 32'h10);
    chk("R4 masked pin no request", {31'h0, irq_shared_o}, 32'h0);
    wr(12'hF08, 32'hEF);
    chk_line("R4 unmask releases request", 20, 1'b1);
    wr(12'hF48, 32'hFF); wr(12'hF08, 32'hFF); wr(12'hE08, 32'h0);

    // R10 two shared pins, 17 and 30, cleared one at a time
    wr(12'hE08, 32'h3 << 4);
    wr(12'hE0C, 32'h3 << 24);
    set_pin(17, 1'b0); set_pin(30, 1'b0); repeat (4) @(posedge clk);
    wr(12'hF48, 32'hFF); wr(12'hF4C, 32'hFF);
    wr(12'hF08, 32'hFD); wr(12'hF0C, 32'hBF);
    set_pin(17, 1'b1); set_pin(30, 1'b1); repeat (4) @(posedge clk);
    #1 chk("R10 two shared pending", {31'h0, irq_shared_o}, 32'h1);
    wr(12'hF48, 32'h02);
    #1 chk("R10 one shared left", {31'h0, irq_shared_o}, 32'h1);
    wr(12'hF4C, 32'h40);
    #1 chk("R10 all shared cleared", {31'h0, irq_shared_o}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule